// File: doc/BRIEF.md
# Burst SRAM with Split Read and Write Ports

This block is a synthesizable behavioural model of a quad-data-rate style burst memory. It has one shared address bus and two active-low port selects, one for reads and one for writes. Everything runs on a single beat clock at twice the access rate. Consecutive beat edges alternate between a K rise and a K# rise, and the first edge after reset is a K rise. An access can only begin on a K rise. Each access moves four words that belong to one internal line of the array.

On every K rise the controller chooses at most one port to start. It uses the operation started on the previous K rise to arbitrate between simultaneous selects and to drop a same-type request that comes too early. Write data is sampled on four consecutive beats, with an active-low mask for each lane. Read data is driven on four consecutive beats, together with a valid indicator that leads the data by one beat and an output enable that drops after the burst.

The array is read on the beat a word leaves the block, not when the request is accepted. A read therefore always returns the newest data, including the words of a write that was started just one K-cycle earlier. Only the low `LINE_AW` address bits select a line; with the defaults the array holds 256 lines of four 8-bit words.

Top module: `burst_mem`

## Requirements
- R1: An access starts only on a K-rise beat edge, when `rdSelN` or `wrSelN` is sampled low. The address is captured on that same edge. Selects that are low on K# edges have no effect.
- R2: A read accepted on beat edge E drives word 0 on edge E+4, then words 1, 2 and 3 on edges E+5, E+6 and E+7.
- R3: The line addressed is `addr[LINE_AW-1:0]`. Beat k of a burst carries word k of that line, and word k occupies line bits [8k+7:8k]. A write accepted on edge E samples its words on edges E+2, E+3, E+4 and E+5.
- R4: A read request on the K rise that follows an accepted read is ignored. A write request on the K rise that follows an accepted write is ignored.
- R5: When both selects are low on a K rise, a read starts if the previous K rise started nothing or started a write, and a write starts if it started a read. Holding both selects low from idle gives read, write, read, and so on. The losing request is dropped.
- R6: A read returns the array contents as they stand after every write beat sampled before each of its output beats. A read that follows a write to the same line by one K-cycle sees the whole new line. A read that precedes a write by one K-cycle sees the old data.
- R7: `wrMaskN[j]` low on a write beat stores `wrData[4j+3:4j]` into that word's lane j. A lane whose mask bit is high keeps its previous contents.
- R8: `rdValid` is high after edges E+3 through E+6 of every read accepted on edge E, one beat ahead of the data. Back-to-back reads keep it high.
- R9: `rdOe` is high after edges E+4 through E+7 and falls on the next K-rise edge once no burst follows. Reads accepted two K-cycles apart give an unbroken enable.
- R10: While `rst` is high and after its release, `rdValid` and `rdOe` are low and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; edges alternate K rise, K# rise |
| rst | input | 1 | Synchronous active-high reset |
| rdSelN | input | 1 | Read port select, active low |
| wrSelN | input | 1 | Write port select, active low |
| addr | input | ADDR_W | Shared request address |
| wrData | input | WORD_W | Write word for the current beat |
| wrMaskN | input | WORD_W/LANE_W | Active-low lane write mask for the current beat |
| rdData | output | WORD_W | Read word |
| rdValid | output | 1 | Read valid, one beat ahead of the data |
| rdOe | output | 1 | Read output enable (low models high impedance) |

## Verification
The assertions assume that the beat clock runs without gaps, so that K and K# edges strictly alternate from the first edge after reset. They also assume that `wrData` and `wrMaskN` hold meaningful values on every beat of a write burst. The stimulus keeps to this: it changes inputs only on falling clock edges, and it advances phase by counting beats from reset. On K# edges it drives both selects low and garbage on the data lines, so that any access that starts off-phase or samples outside its window becomes visible. Every scenario ends with enough idle K-cycles that the next scenario begins from an idle arbitration history.

// File: rtl/burst_mem_pkg.sv
package burst_mem_pkg;

  localparam int unsigned BURST_LEN = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } opKind_e;

  // Per-beat strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       kPhase;     // the coming edge is a K rise
    logic       wrBeat;     // store a write word on this edge
    logic [1:0] wrIdx;      // word index within the line
    logic       rdBeat;     // drive a read word on this edge
    logic [1:0] rdIdx;
    logic       validNext;
    logic       oeNext;
  } beatStrobes_t;

endpackage

// File: rtl/burst_mem_ctrl.sv
module burst_mem_ctrl
  import burst_mem_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned LINE_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rdSelN,
  input  logic               wrSelN,
  input  logic [ADDR_W-1:0]  addr,
  output beatStrobes_t       str,
  output logic [LINE_AW-1:0] wrLine,
  output logic [LINE_AW-1:0] rdLine
);

  localparam int unsigned RD_LAT = BURST_LEN;   // beats from request to word 0
  localparam int unsigned CNT_W  = $clog2(BURST_LEN + 1);

  logic               kPhase;
  opKind_e            lastOp;
  logic               rdStart, wrStart;
  logic [LINE_AW-1:0] reqLine;

  assign reqLine = addr[LINE_AW-1:0];

  generate
    if (ADDR_W > LINE_AW) begin : g_hiAddr
      logic unusedAddrHi;
      assign unusedAddrHi = ^addr[ADDR_W-1:LINE_AW];
    end
  endgenerate

  // Arbitration on K rises only; history is the previous K rise.
  always_comb begin
    rdStart = kPhase && !rdSelN && (lastOp != OP_RD);
    wrStart = kPhase && !wrSelN && (lastOp != OP_WR) && !rdStart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kPhase <= 1'b1;
      lastOp <= OP_NONE;
    end else begin
      kPhase <= !kPhase;
      if (kPhase) begin
        lastOp <= rdStart ? OP_RD : (wrStart ? OP_WR : OP_NONE);
      end
    end
  end

  // Read: delay line of accepted requests, then a four-beat drive counter.
  logic [RD_LAT-1:0]  rdPipeV;
  logic [LINE_AW-1:0] rdPipeA [RD_LAT];
  logic [CNT_W-1:0]   rdLeft;
  logic [LINE_AW-1:0] rdLineQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPipeV <= '0;
      rdLeft  <= '0;
      rdLineQ <= '0;
      for (int i = 0; i < RD_LAT; i++) rdPipeA[i] <= '0;
    end else begin
      rdPipeV    <= {rdPipeV[RD_LAT-2:0], rdStart};
      rdPipeA[0] <= reqLine;
      for (int i = 1; i < RD_LAT; i++) rdPipeA[i] <= rdPipeA[i-1];
      if (rdPipeV[RD_LAT-1]) begin
        rdLineQ <= rdPipeA[RD_LAT-1];
        rdLeft  <= CNT_W'(BURST_LEN - 1);
      end else if (rdLeft != '0) begin
        rdLeft <= rdLeft - 1'b1;
      end
    end
  end

  // Write: one idle beat after the request, then four sampled beats.
  logic               wrWait;
  logic [LINE_AW-1:0] wrPendA;
  logic [CNT_W-1:0]   wrLeft;
  logic [LINE_AW-1:0] wrLineQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrWait  <= 1'b0;
      wrPendA <= '0;
      wrLeft  <= '0;
      wrLineQ <= '0;
    end else begin
      wrWait <= wrStart;
      if (wrStart) wrPendA <= reqLine;
      if (wrWait) begin
        wrLeft  <= CNT_W'(BURST_LEN);
        wrLineQ <= wrPendA;
      end else if (wrLeft != '0) begin
        wrLeft <= wrLeft - 1'b1;
      end
    end
  end

  always_comb begin
    str.kPhase    = kPhase;
    str.wrBeat    = (wrLeft != '0);
    str.wrIdx     = 2'(CNT_W'(BURST_LEN) - wrLeft);
    str.rdBeat    = rdPipeV[RD_LAT-1] || (rdLeft != '0);
    str.rdIdx     = rdPipeV[RD_LAT-1] ? 2'd0 : 2'(CNT_W'(BURST_LEN) - rdLeft);
    str.validNext = rdPipeV[RD_LAT-2] || rdPipeV[RD_LAT-1] || (rdLeft > CNT_W'(1));
    str.oeNext    = str.rdBeat;
    wrLine        = wrLineQ;
    rdLine        = rdPipeV[RD_LAT-1] ? rdPipeA[RD_LAT-1] : rdLineQ;
  end

  AST_RD_SPACING: assert property (@(posedge clk) disable iff (rst)
    rdStart |=> !rdStart ##1 !rdStart ##1 !rdStart);  // R4
  AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
    wrStart |=> !wrStart ##1 !wrStart ##1 !wrStart);  // R4
  AST_START_ON_K: assert property (@(posedge clk) disable iff (rst)
    (rdStart || wrStart) |=> !kPhase);  // R1

endmodule

// File: rtl/burst_mem_dp.sv
module burst_mem_dp
  import burst_mem_pkg::*;
#(
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned LANE_W  = 4,
  parameter int unsigned LINE_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  beatStrobes_t             str,
  input  logic [LINE_AW-1:0]       wrLine,
  input  logic [LINE_AW-1:0]       rdLine,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [WORD_W/LANE_W-1:0] wrMaskN,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid,
  output logic                     rdOe
);

  localparam int unsigned LANES  = WORD_W / LANE_W;
  localparam int unsigned LINE_W = WORD_W * BURST_LEN;
  localparam int unsigned LINES  = 1 << LINE_AW;

  logic [LINE_W-1:0] mem [LINES];

  // Lane-masked word store; the array has no reset.
  always_ff @(posedge clk) begin
    if (!rst && str.wrBeat) begin
      for (int j = 0; j < LANES; j++) begin
        if (!wrMaskN[j]) begin
          mem[wrLine][int'(str.wrIdx)*WORD_W + j*LANE_W +: LANE_W] <= wrData[j*LANE_W +: LANE_W];
        end
      end
    end
  end

  // Output register: reads the array as it stands before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      rdOe    <= 1'b0;
    end else begin
      if (str.rdBeat) rdData <= mem[rdLine][int'(str.rdIdx)*WORD_W +: WORD_W];
      rdValid <= str.validNext;
      rdOe    <= str.oeNext;
    end
  end

  AST_OE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(rdOe) |-> $past(rdValid));  // R8
  AST_VALID_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(rdValid) |=> rdValid ##1 rdValid ##1 rdValid);  // R8
  AST_OE_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(rdOe) |=> rdOe ##1 rdOe ##1 rdOe);  // R9
  AST_OE_DROP_ON_K: assert property (@(posedge clk) disable iff (rst)
    $fell(rdOe) |-> $past(str.kPhase));  // R9

endmodule

// File: rtl/burst_mem.sv
module burst_mem
  import burst_mem_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned LANE_W  = 4,
  parameter int unsigned LINE_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rdSelN,
  input  logic                     wrSelN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [WORD_W/LANE_W-1:0] wrMaskN,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid,
  output logic                     rdOe
);

  beatStrobes_t       str;
  logic [LINE_AW-1:0] wrLine, rdLine;

  burst_mem_ctrl #(.ADDR_W(ADDR_W), .LINE_AW(LINE_AW)) u_ctrl (
    .clk(clk), .rst(rst), .rdSelN(rdSelN), .wrSelN(wrSelN), .addr(addr),
    .str(str), .wrLine(wrLine), .rdLine(rdLine)
  );

  burst_mem_dp #(.WORD_W(WORD_W), .LANE_W(LANE_W), .LINE_AW(LINE_AW)) u_dp (
    .clk(clk), .rst(rst), .str(str), .wrLine(wrLine), .rdLine(rdLine),
    .wrData(wrData), .wrMaskN(wrMaskN),
    .rdData(rdData), .rdValid(rdValid), .rdOe(rdOe)
  );

endmodule

// File: tb/burst_mem_bench.sv
module burst_mem_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXK = 32;
  localparam int MAXB = 2 * MAXK + 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdSelN = 1'b1, wrSelN = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  wrMaskN = 2'b11;
  logic [7:0]  rdData;
  logic        rdValid, rdOe;

  always #(CLK_PERIOD/2) clk = !clk;

  burst_mem u_burst_mem (
    .clk(clk), .rst(rst), .rdSelN(rdSelN), .wrSelN(wrSelN), .addr(addr),
    .wrData(wrData), .wrMaskN(wrMaskN), .rdData(rdData), .rdValid(rdValid), .rdOe(rdOe)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Scenario script, one entry per K-cycle.
  bit         scrRd [MAXK];
  bit         scrWr [MAXK];
  logic [18:0] scrAddr [MAXK];
  logic [7:0] scrMask [MAXK];   // active low, bits [2k+1:2k] for beat k
  int         scrLen;

  logic [31:0] refMem [256];
  int          wrSeq = 0;

  // Per-beat expectations of one run.
  bit         eValid [MAXB];
  bit         eOe    [MAXB];
  bit         rdOn   [MAXB];
  logic [7:0] rdLn   [MAXB];
  int         rdIx   [MAXB];
  bit         wOn    [MAXB];
  logic [7:0] wLn    [MAXB];
  int         wIx    [MAXB];
  logic [7:0] wDat   [MAXB];
  logic [1:0] wMsk   [MAXB];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearScript();
    for (int i = 0; i < MAXK; i++) begin
      scrRd[i] = 0; scrWr[i] = 0; scrAddr[i] = '0; scrMask[i] = 8'h00;
    end
    scrLen = 0;
  endtask

  task automatic addK(input bit rd, input bit wr, input logic [18:0] a, input logic [7:0] m);
    scrRd[scrLen] = rd; scrWr[scrLen] = wr; scrAddr[scrLen] = a; scrMask[scrLen] = m;
    scrLen++;
  endtask

  // Plays the script beat by beat; bench-side arbitration and timing from R1..R9.
  task automatic runScript(input string tag);
    int prevOp;
    int nb;
    logic [7:0] expD;
    prevOp = 0;
    nb = 2 * scrLen + 12;
    for (int i = 0; i < MAXB; i++) begin
      eValid[i] = 0; eOe[i] = 0; rdOn[i] = 0; wOn[i] = 0;
    end
    for (int b = 0; b < nb; b++) begin
      if (b % 2 == 0) begin
        int k;
        bit sRd, sWr;
        k = b / 2;
        sRd = 0; sWr = 0;
        if (k < scrLen) begin
          sRd = scrRd[k] && (prevOp != 1);
          sWr = scrWr[k] && (prevOp != 2) && !sRd;
          rdSelN = !scrRd[k]; wrSelN = !scrWr[k]; addr = scrAddr[k];
        end else begin
          rdSelN = 1'b1; wrSelN = 1'b1; addr = 19'h5A5A5;
        end
        if (sRd) begin
          for (int j = 0; j < 4; j++) begin
            rdOn[b+4+j] = 1; rdLn[b+4+j] = scrAddr[k][7:0]; rdIx[b+4+j] = j;
            eValid[b+3+j] = 1; eOe[b+4+j] = 1;
          end
        end
        if (sWr) begin
          wrSeq++;
          for (int j = 0; j < 4; j++) begin
            wOn[b+2+j] = 1; wLn[b+2+j] = scrAddr[k][7:0]; wIx[b+2+j] = j;
            wDat[b+2+j] = 8'(wrSeq * 29 + j * 67 + 3);
            wMsk[b+2+j] = scrMask[k][2*j +: 2];
          end
        end
        prevOp = sRd ? 1 : (sWr ? 2 : 0);
      end else begin
        // R1: selects low on K# edges must start nothing
        rdSelN = 1'b0; wrSelN = 1'b0; addr = 19'(b * 977);
      end
      if (wOn[b]) begin
        wrData = wDat[b]; wrMaskN = wMsk[b];
      end else begin
        wrData = 8'(8'hA5 ^ b); wrMaskN = 2'b00;
      end
      @(posedge clk);
      expD = rdOn[b] ? refMem[rdLn[b]][rdIx[b]*8 +: 8] : 8'h00;
      if (wOn[b]) begin
        for (int j = 0; j < 2; j++)
          if (!wMsk[b][j]) refMem[wLn[b]][wIx[b]*8 + j*4 +: 4] = wDat[b][j*4 +: 4];
      end
      @(negedge clk);
      chk(rdValid === eValid[b], "R8", {tag, " rdValid"}, 32'(rdValid), 32'(eValid[b]));
      chk(rdOe === eOe[b], "R9", {tag, " rdOe"}, 32'(rdOe), 32'(eOe[b]));
      if (eOe[b]) chk(rdData === expD, tag, "rdData", 32'(rdData), 32'(expD));
    end
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rdValid === 1'b0 && rdOe === 1'b0, "R10", "outputs during reset",
          32'({rdValid, rdOe}), 32'(0));
    end
    rst = 1'b0;  // released at a falling edge; next rising edge is a K rise
  endtask

  task automatic testFillAndStream();   // R2 R3 R1
    clearScript();
    for (int i = 1; i <= 6; i++) begin
      addK(0, 1, 19'(i), 8'h00); addK(0, 0, '0, 8'h00);
    end
    for (int i = 1; i <= 4; i++) begin
      addK(1, 0, 19'(i), 8'h00); addK(0, 0, '0, 8'h00);
    end
    runScript("R2 R3 R1 stream");
  endtask

  task automatic testDropEarly();       // R4
    clearScript();
    addK(0, 1, 19'd5, 8'h00);
    addK(0, 1, 19'd6, 8'h00);   // dropped
    addK(1, 0, 19'd6, 8'h00);
    addK(1, 0, 19'd5, 8'h00);   // dropped
    addK(1, 0, 19'd5, 8'h00);
    runScript("R4 drop");
  endtask

  task automatic testBothSelected();    // R5 R6
    clearScript();
    for (int i = 0; i < 8; i++) addK(1, 1, 19'(2 + i / 2), 8'h00);
    runScript("R5 R6 alternate");
  endtask

  task automatic testLaneMask();        // R7
    clearScript();
    addK(0, 1, 19'd1, 8'b01_10_11_00);
    addK(0, 0, '0, 8'h00);
    addK(1, 0, 19'd1, 8'h00);
    addK(0, 0, '0, 8'h00);
    addK(0, 1, 19'd3, 8'b11_11_11_11);  // no lane written
    addK(1, 0, 19'd3, 8'h00);
    runScript("R7 mask");
  endtask

  task automatic testReadBeforeWrite(); // R6
    clearScript();
    addK(1, 0, 19'd4, 8'h00);
    addK(0, 1, 19'd4, 8'h00);
    addK(0, 0, '0, 8'h00);
    addK(1, 0, 19'd4, 8'h00);
    runScript("R6 order");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 'x;
    testReset();
    testFillAndStream();
    testDropEarly();
    testBothSelected();
    testLaneMask();
    testReadBeforeWrite();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule